// File: doc/BRIEF.md
# Interrupt Acceptance and Status Flag Unit

This unit keeps the interrupt-related processor status flags and decides, one request at a time, whether an incoming interrupt is taken. It holds a register bank selector, an overflow flag, a maskable-interrupt enable, a stack pointer selector and a processor priority level. A maskable hardware request is taken only when interrupts are enabled and its level is strictly above the current priority level. A software interrupt request is always taken.

When a request is taken, the unit raises a one-cycle accept strobe. In that same cycle the flags show their new values, all changed together at one clock edge. Software can write any flag field directly through a per-field write mask. The arithmetic unit supplies only an overflow result bit and a valid bit. Vector fetch and context saving are done by the surrounding pipeline, which watches the accept strobe.

Top module: `irq_flag_ctrl`

## Requirements
- R1: Reset (rst_n low) clears every flag to 0: bank 0, overflow 0, interrupts disabled, interrupt stack pointer selected, priority level 0. It also clears the accept strobe.
- R2: flags_o bit layout: bit 0 = bank select, bit 1 = overflow, bit 2 = interrupt enable, bit 3 = stack select, bits 6:4 = priority level, bit 7 = reserved. A wr_mask_i bit updates the field with the same index (0 bank, 1 overflow, 2 enable, 3 stack select, 4 priority level) from wr_data_i at the next edge. bank_sel_o and stk_sel_o equal bits 0 and 3.
- R3: When ovf_vld_i is high, the overflow flag takes ovf_i at the next edge. This update wins over a direct write to the overflow field in the same cycle.
- R4: A hardware request (req_src_i = 0) is accepted only if the enable flag is 1 and req_lvl_i is strictly greater than the priority level. An equal level is not accepted, and level 7 can never be accepted over a priority level of 7.
- R5: When a hardware request is accepted, ack_o is high for the following cycle. In that same cycle the enable flag and the stack select flag read 0, and the priority level reads the accepted request's level.
- R6: A software request (req_src_i = 1) is accepted whatever the enable flag and priority level are. It leaves both of them unchanged.
- R7: An accepted software request with a number below 32 clears the stack select flag. A number of 32 or more leaves it as it was, or as a same-cycle write sets it.
- R8: When a direct write and an accepted hardware request fall in the same cycle, the acceptance decides the enable flag, the stack select flag and the priority level. Other written fields still take the written value.
- R9: The reserved bit 7 always reads 0. The value written to it has no effect.
- R10: If req_vld_i is low, or a request is rejected, ack_o stays low and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld_i | input | 1 | A request is offered this cycle |
| req_src_i | input | 1 | Request source: 0 hardware, 1 software |
| req_lvl_i | input | LVL_W (3) | Priority level of a hardware request |
| req_swnum_i | input | SWNUM_W (6) | Software interrupt number |
| wr_mask_i | input | 5 | Per-field direct write strobes |
| wr_data_i | input | LVL_W+5 (8) | Direct write data in flags_o layout |
| ovf_vld_i | input | 1 | Arithmetic result valid this cycle |
| ovf_i | input | 1 | Arithmetic overflow bit |
| ack_o | output | 1 | One-cycle accept strobe |
| flags_o | output | LVL_W+5 (8) | Current flag word |
| bank_sel_o | output | 1 | Register bank select (0 bank 0, 1 bank 1) |
| stk_sel_o | output | 1 | Stack select (0 interrupt SP, 1 user SP) |

## Verification
The bench builds the unit with its default parameters: a 3-bit priority level, a 6-bit software number and a stack-clear limit of 32. With these values every priority level from 0 to 7 can be driven, including the top level that can never win against itself. Software numbers reach both sides of the 31/32 boundary. Every field of the 8-bit word, including the reserved top bit, can also be written directly.

// File: rtl/irq_flag_pkg.sv
// Shared field indices, source encoding and decision record for the
// interrupt flag unit. Assumes a flag word of single-bit flags in bits 3:0
// followed by the priority level, with one reserved bit on top.
package irq_flag_pkg;

    // Bit index of each single-bit flag; also the write-mask index
    localparam int F_BANK = 0;
    localparam int F_OVF  = 1;
    localparam int F_IEN  = 2;
    localparam int F_STK  = 3;
    localparam int F_LVL  = 4;   // start of the priority-level field
    localparam int N_BITF = 4;   // number of single-bit flags
    localparam int WM_W   = 5;   // write-mask width

    typedef enum logic {
        SRC_HW = 1'b0,
        SRC_SW = 1'b1
    } irq_src_e;

    // Outcome of the acceptance decision for one cycle
    typedef struct packed {
        logic acc_hw;    // maskable hardware request taken
        logic acc_sw;    // software request taken
        logic clr_stk;   // stack select must drop to 0
    } acc_dec_t;

endpackage

// File: rtl/irq_accept_arb.sv
// Combinational acceptance decision. A hardware request needs the enable
// flag set and a level strictly above the current priority level. A
// software request is always taken. It clears the stack select only
// when its number is below SW_STK_LIMIT.
// Assumes SW_STK_LIMIT fits in SWNUM_W+1 bits.
module irq_accept_arb
    import irq_flag_pkg::*;
#(
    parameter int LVL_W        = 3,
    parameter int SWNUM_W      = 6,
    parameter int SW_STK_LIMIT = 32
) (
    input  logic               req_vld,
    input  logic               req_src,
    input  logic [LVL_W-1:0]   req_lvl,
    input  logic [SWNUM_W-1:0] req_swnum,
    input  logic               ien,
    input  logic [LVL_W-1:0]   ipl,
    output acc_dec_t           dec
);

    localparam logic [SWNUM_W:0] STK_LIM = (SWNUM_W+1)'(SW_STK_LIMIT);

    logic is_sw;
    logic lvl_wins;
    logic low_swnum;

    // Classify the request and compare against the masking state
    always_comb begin
        is_sw     = (irq_src_e'(req_src) == SRC_SW);
        lvl_wins  = (req_lvl > ipl);
        low_swnum = ({1'b0, req_swnum} < STK_LIM);
    end

    // Form the decision record
    always_comb begin
        dec.acc_hw  = req_vld && !is_sw && ien && lvl_wins;
        dec.acc_sw  = req_vld && is_sw;
        dec.clr_stk = dec.acc_hw || (dec.acc_sw && low_swnum);
    end

endmodule

// File: rtl/irq_flag_bit.sv
// One single-bit status flag. An internal update (hw_en) takes priority
// over a direct write (wr_en) in the same cycle.
// Assumes a synchronous active-low reset to 0.
module irq_flag_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_val,
    input  logic hw_en,
    input  logic hw_val,
    output logic q
);

    // Hold the flag, internal update first, then direct write
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (hw_en)
            q <= hw_val;
        else if (wr_en)
            q <= wr_val;
    end

endmodule

// File: rtl/irq_lvl_reg.sv
// Processor priority level register. Loading the accepted request's level
// takes priority over a direct write in the same cycle.
// Assumes a synchronous active-low reset to level 0.
module irq_lvl_reg #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LVL_W-1:0] wr_val,
    input  logic             ld_en,
    input  logic [LVL_W-1:0] ld_val,
    output logic [LVL_W-1:0] q
);

    // Hold the level, acceptance load first, then direct write
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (ld_en)
            q <= ld_val;
        else if (wr_en)
            q <= wr_val;
    end

endmodule

// File: rtl/irq_flag_ctrl.sv
// Interrupt acceptance and status flag unit. It decides whether to take a
// request each cycle. It updates all affected flags at one edge and
// registers the accept strobe, so the strobe and the new flags show in
// the same cycle. Assumes the inputs are synchronous to clk, and a
// synchronous active-low reset.
module irq_flag_ctrl
    import irq_flag_pkg::*;
#(
    parameter int  LVL_W        = 3,
    parameter int  SWNUM_W      = 6,
    parameter int  SW_STK_LIMIT = 32,
    localparam int WORD_W       = LVL_W + 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_vld_i,
    input  logic               req_src_i,
    input  logic [LVL_W-1:0]   req_lvl_i,
    input  logic [SWNUM_W-1:0] req_swnum_i,
    input  logic [WM_W-1:0]    wr_mask_i,
    input  logic [WORD_W-1:0]  wr_data_i,
    input  logic               ovf_vld_i,
    input  logic               ovf_i,
    output logic               ack_o,
    output logic [WORD_W-1:0]  flags_o,
    output logic               bank_sel_o,
    output logic               stk_sel_o
);

    localparam int RSVD_BIT = WORD_W - 1;

    acc_dec_t           dec;
    logic [N_BITF-1:0]  bit_q;
    logic [N_BITF-1:0]  bit_hw_en;
    logic [N_BITF-1:0]  bit_hw_val;
    logic [LVL_W-1:0]   ipl_q;
    logic               ack_q;
    logic               unused_rsvd;

    assign unused_rsvd = wr_data_i[RSVD_BIT];

    irq_accept_arb #(
        .LVL_W        (LVL_W),
        .SWNUM_W      (SWNUM_W),
        .SW_STK_LIMIT (SW_STK_LIMIT)
    ) u_arb (
        .req_vld   (req_vld_i),
        .req_src   (req_src_i),
        .req_lvl   (req_lvl_i),
        .req_swnum (req_swnum_i),
        .ien       (bit_q[F_IEN]),
        .ipl       (ipl_q),
        .dec       (dec)
    );

    // Route internal updates to each single-bit flag
    always_comb begin
        bit_hw_en            = '0;
        bit_hw_val           = '0;
        bit_hw_en[F_OVF]     = ovf_vld_i;
        bit_hw_val[F_OVF]    = ovf_i;
        bit_hw_en[F_IEN]     = dec.acc_hw;
        bit_hw_val[F_IEN]    = 1'b0;
        bit_hw_en[F_STK]     = dec.clr_stk;
        bit_hw_val[F_STK]    = 1'b0;
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_BITF; gi++) begin : g_bitf
            irq_flag_bit u_bit (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (wr_mask_i[gi]),
                .wr_val (wr_data_i[gi]),
                .hw_en  (bit_hw_en[gi]),
                .hw_val (bit_hw_val[gi]),
                .q      (bit_q[gi])
            );
        end
    endgenerate

    irq_lvl_reg #(
        .LVL_W (LVL_W)
    ) u_lvl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_mask_i[F_LVL]),
        .wr_val (wr_data_i[F_LVL +: LVL_W]),
        .ld_en  (dec.acc_hw),
        .ld_val (req_lvl_i),
        .q      (ipl_q)
    );

    // Register the accept strobe so it lines up with the flag update
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_q <= 1'b0;
        else
            ack_q <= dec.acc_hw | dec.acc_sw;
    end

    // Assemble the flag word and the select outputs
    always_comb begin
        flags_o                    = '0;
        flags_o[N_BITF-1:0]        = bit_q;
        flags_o[F_LVL +: LVL_W]    = ipl_q;
        flags_o[RSVD_BIT]          = 1'b0;
        bank_sel_o                 = bit_q[F_BANK];
        stk_sel_o                  = bit_q[F_STK];
        ack_o                      = ack_q;
    end

endmodule

// File: rtl/irq_flag_ctrl_chk.sv
// Property checker for the interrupt flag unit. It looks only at the top
// module's ports and is attached with a bind statement.
module irq_flag_ctrl_chk
    import irq_flag_pkg::*;
#(
    parameter int  LVL_W        = 3,
    parameter int  SWNUM_W      = 6,
    parameter int  SW_STK_LIMIT = 32,
    localparam int WORD_W       = LVL_W + 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_vld_i,
    input logic               req_src_i,
    input logic [LVL_W-1:0]   req_lvl_i,
    input logic [SWNUM_W-1:0] req_swnum_i,
    input logic [WM_W-1:0]    wr_mask_i,
    input logic [WORD_W-1:0]  wr_data_i,
    input logic               ovf_vld_i,
    input logic               ovf_i,
    input logic               ack_o,
    input logic [WORD_W-1:0]  flags_o,
    input logic               bank_sel_o,
    input logic               stk_sel_o
);

    logic [LVL_W-1:0] ipl;
    logic             sw_hi;
    assign ipl   = flags_o[F_LVL +: LVL_W];
    assign sw_hi = ({1'b0, req_swnum_i} >= (SWNUM_W+1)'(SW_STK_LIMIT));

    AST_HW_NEEDS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !$past(req_src_i)) |-> $past(flags_o[F_IEN])); // R4

    AST_HW_LVL_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !$past(req_src_i)) |-> ($past(req_lvl_i) > $past(ipl))); // R4

    AST_HW_ACCEPT_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !$past(req_src_i)) |->
        (!flags_o[F_IEN] && !stk_sel_o && ipl == $past(req_lvl_i))); // R5

    AST_SW_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && $past(req_src_i) && $past(wr_mask_i) == '0) |->
        (ipl == $past(ipl) && flags_o[F_IEN] == $past(flags_o[F_IEN]))); // R6

    AST_SW_HI_KEEPS_STK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && req_src_i && sw_hi && !wr_mask_i[F_STK]) |=>
        $stable(stk_sel_o)); // R7

    AST_OVF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_vld_i |=> (flags_o[F_OVF] == $past(ovf_i))); // R3

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask_i[F_BANK] |=> !flags_o[WORD_W-1]); // R9

    AST_NO_REQ_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld_i |=> !ack_o); // R10

endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(
    .LVL_W        (LVL_W),
    .SWNUM_W      (SWNUM_W),
    .SW_STK_LIMIT (SW_STK_LIMIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_vld_i   (req_vld_i),
    .req_src_i   (req_src_i),
    .req_lvl_i   (req_lvl_i),
    .req_swnum_i (req_swnum_i),
    .wr_mask_i   (wr_mask_i),
    .wr_data_i   (wr_data_i),
    .ovf_vld_i   (ovf_vld_i),
    .ovf_i       (ovf_i),
    .ack_o       (ack_o),
    .flags_o     (flags_o),
    .bank_sel_o  (bank_sel_o),
    .stk_sel_o   (stk_sel_o)
);

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_vld, req_src;
    logic [2:0] req_lvl;
    logic [5:0] req_num;
    logic [4:0] wr_mask;
    logic [7:0] wr_data;
    logic       ovf_vld, ovf;
    logic       ack;
    logic [7:0] flags;
    logic       bank_sel, stk_sel;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_flag_ctrl u_irq_flag_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_vld_i(req_vld), .req_src_i(req_src), .req_lvl_i(req_lvl),
        .req_swnum_i(req_num), .wr_mask_i(wr_mask), .wr_data_i(wr_data),
        .ovf_vld_i(ovf_vld), .ovf_i(ovf),
        .ack_o(ack), .flags_o(flags), .bank_sel_o(bank_sel), .stk_sel_o(stk_sel)
    );

    typedef struct packed {
        logic [4:0] mask;
        logic [7:0] data;
        logic       ov_vld;
        logic       ov;
        logic       vld;
        logic       sw;
        logic [2:0] lvl;
        logic [5:0] num;
        logic       e_ack;
        logic [7:0] e_flags;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{5'h1F, 8'hDF, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 6'd0,  1'b0, 8'h5F, 4'd9},  // R9 R2
        '{5'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd5, 6'd0,  1'b0, 8'h5F, 4'd4},  // R4 equal level
        '{5'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd6, 6'd0,  1'b1, 8'h63, 4'd5},  // R5
        '{5'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd7, 6'd0,  1'b0, 8'h63, 4'd4},  // R4 disabled
        '{5'h08, 8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 6'd0,  1'b0, 8'h6B, 4'd2},  // R2
        '{5'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 6'd40, 1'b1, 8'h6B, 4'd7},  // R7 high number
        '{5'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 6'd31, 1'b1, 8'h63, 4'd7},  // R7 number 31
        '{5'h08, 8'h08, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 6'd32, 1'b1, 8'h6B, 4'd7},  // R7 number 32
        '{5'h04, 8'h04, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 6'd0,  1'b0, 8'h6F, 4'd2},  // R2
        '{5'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 3'd7, 6'd0,  1'b1, 8'h67, 4'd6},  // R6
        '{5'h02, 8'h02, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 6'd0,  1'b0, 8'h65, 4'd3},  // R3 ALU wins
        '{5'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 6'd0,  1'b0, 8'h67, 4'd3},  // R3
        '{5'h08, 8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 6'd0,  1'b0, 8'h6F, 4'd2},  // R2
        '{5'h1D, 8'h2C, 1'b0, 1'b0, 1'b1, 1'b0, 3'd7, 6'd0,  1'b1, 8'h72, 4'd8},  // R8
        '{5'h14, 8'h04, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 6'd0,  1'b0, 8'h06, 4'd2},  // R2
        '{5'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 6'd0,  1'b1, 8'h12, 4'd4},  // R4 lowest win
        '{5'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd7, 6'd0,  1'b0, 8'h12, 4'd10}, // R10 idle
        '{5'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd7, 6'd0,  1'b0, 8'h12, 4'd10}  // R10 rejected
    };

    task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] m, input logic [7:0] d, input logic ovv,
                         input logic ov, input logic v, input logic s,
                         input logic [2:0] l, input logic [5:0] n);
        wr_mask = m; wr_data = d; ovf_vld = ovv; ovf = ov;
        req_vld = v; req_src = s; req_lvl = l; req_num = n;
    endtask

    task automatic check_all(input string rq, input logic e_ack, input logic [7:0] e_fl);
        check(rq, {7'd0, ack}, {7'd0, e_ack});
        check(rq, flags, e_fl);
        check("R2", {6'd0, stk_sel, bank_sel}, {6'd0, e_fl[3], e_fl[0]});
    endtask

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(5'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 6'd0);
        repeat (3) @(negedge clk);
        check_all("R1", 1'b0, 8'h00);             // R1 reset state
        rst_n = 1'b1;

        // Table walk: drive at a falling edge, check one rising edge later
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].mask, VEC[i].data, VEC[i].ov_vld, VEC[i].ov,
                  VEC[i].vld, VEC[i].sw, VEC[i].lvl, VEC[i].num);
            @(negedge clk);
            check_all($sformatf("R%0d vec%0d", VEC[i].rq, i), VEC[i].e_ack, VEC[i].e_flags);
        end

        // R4 corner: level 7 cannot beat priority level 7
        drive(5'h14, 8'h74, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 6'd0);
        @(negedge clk);
        check_all("R4 setup", 1'b0, 8'h76);
        drive(5'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd7, 6'd0);
        @(negedge clk);
        check_all("R4 top level", 1'b0, 8'h76);

        // R5: strobe lasts one cycle only
        drive(5'h14, 8'h04, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 6'd0);
        @(negedge clk);
        drive(5'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd3, 6'd0);
        @(negedge clk);
        check_all("R5 accept", 1'b1, 8'h32);
        drive(5'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 6'd0);
        @(negedge clk);
        check_all("R5 strobe drop", 1'b0, 8'h32);

        // R1: reset in mid-run clears everything
        drive(5'h1F, 8'h7F, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 6'd0);
        @(negedge clk);
        rst_n = 1'b0;
        drive(5'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 6'd0);
        @(negedge clk);
        check_all("R1 mid-run", 1'b0, 8'h00);
        rst_n = 1'b1;
        drive(5'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 6'd0);
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule